// File: doc/BRIEF.md
# Four-Line Write-Invalidate Coherence State Controller

This block keeps the coherence state of four cache lines for one core of a snooping multi-core system. Each line carries a two-bit state, an address tag and a 64-byte data block. The core issues reads and whole-line writes. The block answers read hits from its own storage. A read miss is filled from the data presented with the request. A write that does not already own the line is held back until every peer core has acknowledged an invalidate broadcast. Only then is the new data stored and the line marked Modified.

On the bus side the block watches remote reads and writes. A remote read demotes an owned line to Shared. A remote write drops the line to Invalid. When a Modified line is about to stop being the only valid copy, the block emits a one-cycle writeback pulse carrying the line's tag and data. This happens on a snoop and on an eviction. A pulse on the snoop-hit output tells the bus that this core held a copy, and peers use that to decide between Exclusive and Shared on their own fills. Peer copies are never updated in place.

Top module: `coh_line_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every line is Invalid, so the first access to any tag misses. `resp_valid`, `inv_valid`, `wb_valid` and `snp_hit` are low, and `req_ready` is high once `rst` is low.
- R2: A read miss is answered one cycle after acceptance with `resp_hit`=0 and `resp_rdata`=`fill_data`. The line is installed as Exclusive (state code 2) when `fill_shared` is 0 and as Shared (code 1) when it is 1. Modified is code 3 and Invalid is code 0.
- R3: A read hit is answered one cycle after acceptance with `resp_hit`=1 and the stored block. The line's state does not change.
- R4: A write that hits an Exclusive or Modified line completes one cycle after acceptance with no invalidate broadcast. The line becomes Modified and holds the new block.
- R5: A write that hits a Shared line, or that misses, raises `inv_valid` with `inv_tag` one cycle after acceptance. `inv_valid` stays high until every bit of `peer_ack` has been seen high at least once, in any order and on any cycles. It falls in the same cycle that `resp_valid` rises, and the line is then Modified with the new block.
- R6: While an invalidate is outstanding, `req_ready` is low and no new core request is taken.
- R7: A remote read that hits an Exclusive line turns it Shared without a writeback, so a later local write to it must broadcast an invalidate. A remote read of a Shared line leaves it Shared. Any snoop that hits a held line pulses `snp_hit` one cycle later.
- R8: A remote read that hits a Modified line pulses `wb_valid` one cycle later with that line's tag and block, and leaves the line Shared.
- R9: A remote write that hits a held line makes it Invalid, so the next local read of that tag misses. If the line was Modified, `wb_valid` pulses first with its tag and block.
- R10: A snoop has priority over the core. `req_ready` is low in any cycle with `snp_valid` high, and a pending write whose last acknowledgement coincides with a snoop completes one cycle later, with that acknowledgement remembered.
- R11: A miss takes the lowest-numbered Invalid line. When no line is Invalid it takes line `evict_way`, and if that line was Modified, `wb_valid` pulses one cycle after acceptance with its old tag and block. No other line is disturbed.
- R12: A snoop whose tag matches no held line gives `snp_hit`=0 and no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = whole-line write, 0 = read |
| req_tag | input | TAG_W | Line address tag of the request |
| req_wdata | input | DATA_W | Block to store on a write |
| fill_data | input | DATA_W | Memory block used when a read misses |
| fill_shared | input | 1 | A peer holds the line being filled |
| evict_way | input | IDX_W | Line to replace when none is Invalid |
| req_ready | output | 1 | Request is accepted at the next edge |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | Completed request hit a held line |
| resp_rdata | output | DATA_W | Read data, valid with a read completion |
| inv_valid | output | 1 | Invalidate broadcast outstanding |
| inv_tag | output | TAG_W | Tag being invalidated |
| peer_ack | input | PEERS | Per-peer invalidate acknowledgement pulses |
| snp_valid | input | 1 | Remote bus transaction observed |
| snp_write | input | 1 | 1 = remote write, 0 = remote read |
| snp_tag | input | TAG_W | Tag of the remote transaction |
| snp_hit | output | 1 | Snooped tag was held here (one cycle later) |
| wb_valid | output | 1 | One-cycle writeback request |
| wb_tag | output | TAG_W | Tag of the block being written back |
| wb_data | output | DATA_W | Block being written back |

## Verification
The bench drives acknowledgements one peer at a time and out of order. A controller that completes on the first or on any single acknowledgement drops `inv_valid` early. The last acknowledgement is also made to coincide with a snoop, which catches a design that either forgets that acknowledgement and hangs, or completes in the snoop cycle. The sequence demotes Exclusive and Modified lines through remote reads and then writes to them again. A design that upgrades silently from Shared would show no invalidate there, and one that skips the Modified writeback would miss a `wb_valid` pulse. The last part fills every line and evicts a Modified one through `evict_way`, then frees a line with a remote write and checks that the next miss reuses it without disturbing the others. This exposes a wrong victim choice or a lost eviction writeback.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } line_st_e;

  typedef enum logic {
    CTL_IDLE = 1'b0,
    CTL_WAIT = 1'b1
  } ctl_e;

  // State a held line takes after a remote access.
  function automatic line_st_e snoop_next(line_st_e cur, logic remote_wr);
    if (cur == LS_INV) return LS_INV;
    if (remote_wr)     return LS_INV;
    return LS_SHR;
  endfunction

  // Line may be written locally without telling anyone.
  function automatic logic owns_line(line_st_e s);
    return (s == LS_EXC) || (s == LS_MOD);
  endfunction

endpackage

// File: rtl/coh_tag_match.sv
module coh_tag_match #(
  parameter int LINES = 4,
  parameter int TAG_W = 20,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic [LINES-1:0] live,
  input  logic [TAG_W-1:0] tags [LINES],
  input  logic [TAG_W-1:0] key,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  logic [LINES-1:0] eq;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign eq[g] = live[g] && (tags[g] == key);
  end

  always_comb begin
    hit = |eq;
    idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/coh_victim_pick.sv
module coh_victim_pick #(
  parameter int LINES = 4,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic [LINES-1:0] live,
  input  logic [IDX_W-1:0] fallback,
  output logic [IDX_W-1:0] victim
);

  logic [LINES-1:0] free_v;
  logic [IDX_W-1:0] first_free;

  assign free_v = ~live;

  always_comb begin
    first_free = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (free_v[i]) first_free = IDX_W'(i);
    end
    victim = (|free_v) ? first_free : fallback;
  end

endmodule

// File: rtl/coh_ack_collect.sv
module coh_ack_collect #(
  parameter int PEERS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             enable,
  input  logic [PEERS-1:0] ack_in,
  output logic             all_in
);

  logic [PEERS-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst || clear) seen_q <= '0;
    else if (enable)  seen_q <= seen_q | ack_in;
  end

  // Includes acknowledgements arriving in the current cycle.
  assign all_in = &(seen_q | ack_in);

endmodule

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 512,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_we,
  input  logic [IDX_W-1:0]  st_idx,
  input  line_st_e          st_val,
  input  logic              ln_we,
  input  logic [IDX_W-1:0]  ln_idx,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  output line_st_e          st_all  [LINES],
  output logic [TAG_W-1:0]  tag_all [LINES],
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data
);

  line_st_e          st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] blk_mem [LINES];

  // Only the state field needs a reset; tags and blocks are qualified by it.
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)                                 st_q[g] <= LS_INV;
      else if (st_we && st_idx == IDX_W'(g))   st_q[g] <= st_val;
    end

    always_ff @(posedge clk) begin
      if (ln_we && ln_idx == IDX_W'(g)) tag_q[g] <= ln_tag;
    end

    assign st_all[g]  = st_q[g];
    assign tag_all[g] = tag_q[g];
  end

  always_ff @(posedge clk) begin
    if (ln_we) blk_mem[ln_idx] <= ln_data;
  end

  assign rd_a_data = blk_mem[rd_a_idx];
  assign rd_b_data = blk_mem[rd_b_idx];

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int LINES      = 4,
  parameter int TAG_W      = 20,
  parameter int LINE_BYTES = 64,
  parameter int PEERS      = 3,
  localparam int DATA_W    = LINE_BYTES * 8,
  localparam int IDX_W     = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              fill_shared,
  input  logic [IDX_W-1:0]  evict_way,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              inv_valid,
  output logic [TAG_W-1:0]  inv_tag,
  input  logic [PEERS-1:0]  peer_ack,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [TAG_W-1:0]  snp_tag,
  output logic              snp_hit,
  output logic              wb_valid,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [DATA_W-1:0] wb_data
);

  ctl_e              ctl_q;
  line_st_e          st_all  [LINES];
  logic [TAG_W-1:0]  tag_all [LINES];
  logic [LINES-1:0]  live;

  logic              c_hit, s_hit;
  logic [IDX_W-1:0]  c_idx, s_idx, vic_idx;
  logic [IDX_W-1:0]  rd_a_idx;
  logic [DATA_W-1:0] rd_a_data, rd_b_data;

  logic              st_we, ln_we;
  logic [IDX_W-1:0]  st_idx, ln_idx;
  line_st_e          st_val;
  logic [TAG_W-1:0]  ln_tag;
  logic [DATA_W-1:0] ln_data;

  logic              accept, complete, all_acked;
  logic              c_owns, vic_dirty;

  logic [IDX_W-1:0]  pend_slot;
  logic [TAG_W-1:0]  pend_tag;
  logic [DATA_W-1:0] pend_data;
  logic              pend_hit;

  for (genvar g = 0; g < LINES; g++) begin : g_live
    assign live[g] = (st_all[g] != LS_INV);
  end

  coh_tag_match #(.LINES(LINES), .TAG_W(TAG_W)) u_core_match (
    .live (live),
    .tags (tag_all),
    .key  (req_tag),
    .hit  (c_hit),
    .idx  (c_idx)
  );

  coh_tag_match #(.LINES(LINES), .TAG_W(TAG_W)) u_snoop_match (
    .live (live),
    .tags (tag_all),
    .key  (snp_tag),
    .hit  (s_hit),
    .idx  (s_idx)
  );

  coh_victim_pick #(.LINES(LINES)) u_victim (
    .live     (live),
    .fallback (evict_way),
    .victim   (vic_idx)
  );

  assign req_ready = !rst && (ctl_q == CTL_IDLE) && !snp_valid;
  assign accept    = req_valid && req_ready;
  assign complete  = (ctl_q == CTL_WAIT) && !snp_valid && all_acked;
  assign rd_a_idx  = c_hit ? c_idx : vic_idx;
  assign c_owns    = c_hit && owns_line(st_all[c_idx]);
  assign vic_dirty = !c_hit && (st_all[vic_idx] == LS_MOD);

  coh_ack_collect #(.PEERS(PEERS)) u_acks (
    .clk    (clk),
    .rst    (rst),
    .clear  (accept),
    .enable (ctl_q == CTL_WAIT),
    .ack_in (peer_ack),
    .all_in (all_acked)
  );

  coh_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .st_we     (st_we),
    .st_idx    (st_idx),
    .st_val    (st_val),
    .ln_we     (ln_we),
    .ln_idx    (ln_idx),
    .ln_tag    (ln_tag),
    .ln_data   (ln_data),
    .st_all    (st_all),
    .tag_all   (tag_all),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (rd_a_data),
    .rd_b_idx  (s_idx),
    .rd_b_data (rd_b_data)
  );

  // One writer per cycle: snoop, then core acceptance, then completion.
  always_comb begin
    st_we   = 1'b0;
    st_idx  = '0;
    st_val  = LS_INV;
    ln_we   = 1'b0;
    ln_idx  = '0;
    ln_tag  = req_tag;
    ln_data = req_wdata;
    if (snp_valid) begin
      if (s_hit) begin
        st_we  = 1'b1;
        st_idx = s_idx;
        st_val = snoop_next(st_all[s_idx], snp_write);
      end
    end else if (accept) begin
      if (!req_write) begin
        if (!c_hit) begin
          ln_we   = 1'b1;
          ln_idx  = vic_idx;
          ln_data = fill_data;
          st_we   = 1'b1;
          st_idx  = vic_idx;
          st_val  = fill_shared ? LS_SHR : LS_EXC;
        end
      end else if (c_owns) begin
        ln_we  = 1'b1;
        ln_idx = c_idx;
        st_we  = 1'b1;
        st_idx = c_idx;
        st_val = LS_MOD;
      end else if (!c_hit) begin
        st_we  = 1'b1;
        st_idx = vic_idx;
        st_val = LS_INV;
      end
    end else if (complete) begin
      ln_we   = 1'b1;
      ln_idx  = pend_slot;
      ln_tag  = pend_tag;
      ln_data = pend_data;
      st_we   = 1'b1;
      st_idx  = pend_slot;
      st_val  = LS_MOD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= CTL_IDLE;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_rdata <= '0;
      inv_valid  <= 1'b0;
      inv_tag    <= '0;
      snp_hit    <= 1'b0;
      wb_valid   <= 1'b0;
      wb_tag     <= '0;
      wb_data    <= '0;
      pend_slot  <= '0;
      pend_tag   <= '0;
      pend_data  <= '0;
      pend_hit   <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      wb_valid   <= 1'b0;
      snp_hit    <= 1'b0;
      if (snp_valid) begin
        snp_hit <= s_hit;
        if (s_hit && st_all[s_idx] == LS_MOD) begin
          wb_valid <= 1'b1;
          wb_tag   <= tag_all[s_idx];
          wb_data  <= rd_b_data;
        end
      end else if (accept) begin
        if (vic_dirty && !(req_write && c_hit)) begin
          wb_valid <= 1'b1;
          wb_tag   <= tag_all[vic_idx];
          wb_data  <= rd_a_data;
        end
        if (!req_write) begin
          resp_valid <= 1'b1;
          resp_hit   <= c_hit;
          resp_rdata <= c_hit ? rd_a_data : fill_data;
        end else if (c_owns) begin
          resp_valid <= 1'b1;
          resp_hit   <= 1'b1;
        end else begin
          ctl_q     <= CTL_WAIT;
          inv_valid <= 1'b1;
          inv_tag   <= req_tag;
          pend_slot <= c_hit ? c_idx : vic_idx;
          pend_tag  <= req_tag;
          pend_data <= req_wdata;
          pend_hit  <= c_hit;
        end
      end else if (complete) begin
        ctl_q      <= CTL_IDLE;
        inv_valid  <= 1'b0;
        resp_valid <= 1'b1;
        resp_hit   <= pend_hit;
      end
    end
  end

endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk #(
  parameter int PEERS = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_ready,
  input logic             resp_valid,
  input logic             inv_valid,
  input logic [PEERS-1:0] peer_ack,
  input logic             snp_valid,
  input logic             snp_hit,
  input logic             wb_valid
);

  logic [PEERS-1:0] chk_seen;

  always_ff @(posedge clk) begin
    if (rst || !inv_valid) chk_seen <= '0;
    else                   chk_seen <= chk_seen | peer_ack;
  end

  // R5: the broadcast is held until every peer has answered.
  assert_inv_held_R5: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && !(&(chk_seen | peer_ack))) |=> inv_valid);

  // R5: the broadcast ends exactly when the write completes.
  assert_inv_done_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(inv_valid) |-> resp_valid);

  assert_stall_R6: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> !req_ready);

  assert_snoop_first_R10: assert property (@(posedge clk) disable iff (rst)
    snp_valid |-> !req_ready);

  assert_read_answer_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write) |=> resp_valid);

  // R8 and R11: writebacks only follow a snoop or an accepted request.
  assert_wb_cause_R8: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> ($past(snp_valid) || $past(req_valid && req_ready)));

  assert_snoop_hit_cause_R7: assert property (@(posedge clk) disable iff (rst)
    snp_hit |-> $past(snp_valid));

endmodule

bind coh_line_ctrl coh_line_ctrl_chk #(.PEERS(PEERS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .inv_valid  (inv_valid),
  .peer_ack   (peer_ack),
  .snp_valid  (snp_valid),
  .snp_hit    (snp_hit),
  .wb_valid   (wb_valid)
);

// File: tb/sim_coh_line_ctrl.sv
`timescale 1ns/1ps
module sim_coh_line_ctrl;

  localparam int N  = 4;
  localparam int TW = 20;
  localparam int DW = 512;
  localparam int P  = 3;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          req_valid = 0, req_write = 0, fill_shared = 0;
  logic [TW-1:0] req_tag = '0;
  logic [DW-1:0] req_wdata = '0, fill_data = '0;
  logic [IW-1:0] evict_way = '0;
  logic          req_ready, resp_valid, resp_hit, inv_valid, snp_hit, wb_valid;
  logic [DW-1:0] resp_rdata, wb_data;
  logic [TW-1:0] inv_tag, wb_tag;
  logic [P-1:0]  peer_ack = '0;
  logic          snp_valid = 0, snp_write = 0;
  logic [TW-1:0] snp_tag = '0;

  coh_line_ctrl #(.LINES(N), .TAG_W(TW), .LINE_BYTES(DW/8), .PEERS(P)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_tag(req_tag), .req_wdata(req_wdata), .fill_data(fill_data),
    .fill_shared(fill_shared), .evict_way(evict_way), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .inv_valid(inv_valid), .inv_tag(inv_tag), .peer_ack(peer_ack),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_tag(snp_tag),
    .snp_hit(snp_hit), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit cmp_on   = 0;
  bit done     = 0;

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] blk(int n);
    return {16{32'(n) ^ 32'h5A5A_0000}};
  endfunction

  // ---------------- behavioural reference model ----------------
  int            m_st  [N];
  logic [TW-1:0] m_tag [N];
  logic [DW-1:0] m_dat [N];
  bit            m_busy;
  int            m_slot;
  logic [TW-1:0] m_ptag;
  logic [DW-1:0] m_pdat;
  bit            m_phit;
  logic [P-1:0]  m_acks;
  bit            e_rv, e_rh, e_inv, e_wb, e_sh;
  logic [DW-1:0] e_rd, e_wbd;
  logic [TW-1:0] e_it, e_wbt;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_st[i]) m_st[i] = 0;
      m_busy = 0; m_acks = '0;
      e_rv = 0; e_rh = 0; e_inv = 0; e_wb = 0; e_sh = 0;
    end else begin
      int h, v;
      e_rv = 0; e_wb = 0; e_sh = 0;
      if (m_busy) m_acks = m_acks | peer_ack;
      if (snp_valid) begin
        h = -1;
        for (int i = 0; i < N; i++) if (h < 0 && m_st[i] != 0 && m_tag[i] == snp_tag) h = i;
        if (h >= 0) begin
          e_sh = 1;
          if (m_st[h] == 3) begin e_wb = 1; e_wbt = m_tag[h]; e_wbd = m_dat[h]; end
          m_st[h] = snp_write ? 0 : 1;
        end
      end else if (!m_busy && req_valid) begin
        h = -1; v = -1;
        for (int i = 0; i < N; i++) if (h < 0 && m_st[i] != 0 && m_tag[i] == req_tag) h = i;
        for (int i = 0; i < N; i++) if (v < 0 && m_st[i] == 0) v = i;
        if (v < 0) v = int'(evict_way);
        if (!req_write) begin
          e_rv = 1;
          if (h >= 0) begin e_rh = 1; e_rd = m_dat[h]; end
          else begin
            e_rh = 0; e_rd = fill_data;
            if (m_st[v] == 3) begin e_wb = 1; e_wbt = m_tag[v]; e_wbd = m_dat[v]; end
            m_tag[v] = req_tag; m_dat[v] = fill_data; m_st[v] = fill_shared ? 1 : 2;
          end
        end else if (h >= 0 && m_st[h] >= 2) begin
          m_dat[h] = req_wdata; m_st[h] = 3; e_rv = 1; e_rh = 1;
        end else begin
          m_busy = 1; m_acks = '0; e_inv = 1; e_it = req_tag;
          m_ptag = req_tag; m_pdat = req_wdata; m_phit = (h >= 0);
          if (h >= 0) m_slot = h;
          else begin
            m_slot = v;
            if (m_st[v] == 3) begin e_wb = 1; e_wbt = m_tag[v]; e_wbd = m_dat[v]; end
            m_st[v] = 0;
          end
        end
      end else if (m_busy && m_acks == '1) begin
        m_tag[m_slot] = m_ptag; m_dat[m_slot] = m_pdat; m_st[m_slot] = 3;
        m_busy = 0; e_inv = 0; e_rv = 1; e_rh = m_phit;
      end
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    #1;
    if (cmp_on && !done) begin
      chk("R6/R10", "req_ready", req_ready, !m_busy && !snp_valid);
      chk("R3", "resp_valid", resp_valid, e_rv);
      if (e_rv) begin
        chk("R2", "resp_hit", resp_hit, e_rh);
        if (!req_write || e_rd !== 'x) chk("R3", "resp_rdata", e_rv && e_rd !== 'x ? resp_rdata : '0, e_rd !== 'x ? e_rd : '0);
      end
      chk("R5", "inv_valid", inv_valid, e_inv);
      if (e_inv) chk("R5", "inv_tag", inv_tag, e_it);
      chk("R8", "wb_valid", wb_valid, e_wb);
      if (e_wb) begin
        chk("R8", "wb_tag", wb_tag, e_wbt);
        chk("R8", "wb_data", wb_data, e_wbd);
      end
      chk("R12", "snp_hit", snp_hit, e_sh);
    end
  end

  // ---------------- stimulus helpers ----------------
  logic          g_hit, g_inv, g_wb, g_rv;
  logic [DW-1:0] g_data, g_wbd;
  logic [TW-1:0] g_wbt;

  task automatic core_op(logic wr, logic [TW-1:0] tag, logic [DW-1:0] d, logic shr, logic [IW-1:0] ew);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_tag = tag;
    req_wdata = d; fill_data = d; fill_shared = shr; evict_way = ew;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0;
    #1;
    g_rv = resp_valid; g_hit = resp_hit; g_data = resp_rdata;
    g_inv = inv_valid; g_wb = wb_valid; g_wbt = wb_tag; g_wbd = wb_data;
  endtask

  task automatic snoop(logic wr, logic [TW-1:0] tag);
    @(negedge clk);
    snp_valid = 1; snp_write = wr; snp_tag = tag;
    @(negedge clk);
    snp_valid = 0;
    #1;
    g_hit = snp_hit; g_wb = wb_valid; g_wbt = wb_tag; g_wbd = wb_data;
  endtask

  task automatic ack_cycle(logic [P-1:0] pat);
    @(negedge clk);
    peer_ack = pat;
    @(negedge clk);
    peer_ack = '0;
    #1;
    g_inv = inv_valid; g_rv = resp_valid; g_hit = resp_hit;
  endtask

  localparam logic [TW-1:0] TA = 20'h0A0A1, TB = 20'h0B0B2, TC = 20'h0C0C3,
                            TD = 20'h0D0D4, TE = 20'h0E0E5, TQ = 20'h0F0F6;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "resp_valid in reset", resp_valid, 0);
    chk("R1", "inv_valid in reset", inv_valid, 0);
    chk("R1", "wb_valid in reset", wb_valid, 0);
    @(negedge clk);
    rst = 0;
    cmp_on = 1;
    #1;
    chk("R1", "req_ready after reset", req_ready, 1);

    // Fill as Exclusive, then read hit.
    core_op(0, TA, blk(1), 0, 0);
    chk("R1", "first access misses", g_hit, 0);
    chk("R2", "miss returns fill", g_data, blk(1));
    core_op(0, TA, blk(99), 0, 0);
    chk("R3", "read hit", g_hit, 1);
    chk("R3", "read hit data", g_data, blk(1));

    // Silent upgrade of Exclusive.
    core_op(1, TA, blk(2), 0, 0);
    chk("R4", "no invalidate on E write", g_inv, 0);
    chk("R4", "E write completes", g_rv, 1);
    core_op(0, TA, blk(99), 0, 0);
    chk("R4", "new data stored", g_data, blk(2));

    // Remote read of Modified: writeback and demote.
    snoop(0, TA);
    chk("R8", "snoop of M writes back", g_wb, 1);
    chk("R8", "writeback tag", g_wbt, TA);
    chk("R8", "writeback data", g_wbd, blk(2));
    core_op(1, TA, blk(3), 0, 0);
    chk("R8", "line now Shared needs invalidate", g_inv, 1);
    chk("R6", "stalled while invalidating", req_ready, 0);
    ack_cycle(3'b001);
    chk("R5", "held after one ack", g_inv, 1);
    ack_cycle(3'b100);
    chk("R5", "held after two acks", g_inv, 1);
    ack_cycle(3'b010);
    chk("R5", "released after all acks", g_inv, 0);
    chk("R5", "completion with release", g_rv, 1);
    chk("R5", "completion reports hit", g_hit, 1);
    core_op(0, TA, blk(99), 0, 0);
    chk("R5", "data after invalidate write", g_data, blk(3));

    // Shared fill, remote read, remote write.
    core_op(0, TB, blk(10), 1, 0);
    chk("R2", "shared fill miss", g_hit, 0);
    snoop(0, TB);
    chk("R7", "snoop hit on S", g_hit, 1);
    chk("R7", "no writeback from S", g_wb, 0);
    snoop(1, TB);
    chk("R9", "remote write hit", g_hit, 1);
    core_op(0, TB, blk(11), 1, 0);
    chk("R9", "line invalid after remote write", g_hit, 0);

    // Exclusive demoted by remote read.
    core_op(0, TC, blk(20), 0, 0);
    snoop(0, TC);
    chk("R7", "no writeback from E", g_wb, 0);
    core_op(1, TC, blk(21), 0, 0);
    chk("R7", "demoted E needs invalidate", g_inv, 1);
    ack_cycle(3'b111);
    chk("R5", "all acks together", g_rv, 1);

    snoop(0, TQ);
    chk("R12", "snoop of absent tag", g_hit, 0);
    chk("R12", "no writeback for absent tag", g_wb, 0);

    // Write miss with the final ack meeting a snoop.
    core_op(1, TD, blk(30), 0, 0);
    chk("R5", "write miss invalidates", g_inv, 1);
    chk("R11", "free slot needs no writeback", g_wb, 0);
    ack_cycle(3'b011);
    @(negedge clk);
    peer_ack = 3'b100; snp_valid = 1; snp_write = 0; snp_tag = TQ;
    @(negedge clk);
    peer_ack = '0; snp_valid = 0;
    #1;
    chk("R10", "completion deferred by snoop", inv_valid, 1);
    @(negedge clk);
    #1;
    chk("R10", "remembered ack completes", inv_valid, 0);
    chk("R5", "write miss completion", resp_hit, 0);

    // Snoop and request together.
    @(negedge clk);
    req_valid = 1; req_write = 0; req_tag = TA;
    snp_valid = 1; snp_write = 0; snp_tag = TQ;
    #1;
    chk("R10", "request refused during snoop", req_ready, 0);
    @(negedge clk);
    req_valid = 0; snp_valid = 0;

    // All lines full: evict line 2, which holds TC as Modified.
    core_op(0, TE, blk(40), 0, 2);
    chk("R11", "eviction writes back", g_wb, 1);
    chk("R11", "evicted tag", g_wbt, TC);
    chk("R11", "evicted data", g_wbd, blk(21));

    snoop(1, TA);
    chk("R9", "remote write on M writes back", g_wb, 1);
    chk("R9", "writeback data before invalidate", g_wbd, blk(3));
    core_op(0, TA, blk(50), 0, 1);
    chk("R11", "lowest free slot, no writeback", g_wb, 0);
    chk("R9", "refill after remote write misses", g_hit, 0);
    core_op(0, TE, blk(99), 0, 1);
    chk("R11", "other lines undisturbed", g_data, blk(40));
    core_op(0, TD, blk(99), 0, 1);
    chk("R11", "written line undisturbed", g_data, blk(30));

    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule